// File: doc/BRIEF.md
# External Memory Region Decoder

The block takes an access from a 30-bit internal bus and maps it onto the external memory bus. The 1 GB address space is split into eight fixed 128 MB regions. The three top address bits pick the region, and each region drives its own active-low chip select. The remaining 27 bits go out unchanged as the address inside the region. For writes, the block also drives four active-low byte-lane enables. These depend on the access size, the two low address bits and the data width configured for the selected region.

A small configuration register file holds each region's data width and, for the two top regions only, a flag that marks the region as SDRAM. Software writes this file through a single-cycle write port. A width request that a region cannot take is dropped and the old value stays. The width and SDRAM flag of the region being addressed are output so that the downstream bus logic can use them. The outputs follow the bus inputs combinationally. A configuration write takes effect on the clock edge where it is sampled.

Encodings used throughout:
- Width codes: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = reserved.
- Size codes: 00 = byte, 01 = halfword, 10 = word, 11 = reserved.
- Bit k of `cs_n` and `be_n` belongs to region k and byte lane k.

Top module: `mbd_region_decode`

## Requirements
- R1: For an enabled, aligned access, exactly the chip select `cs_n[k]` with k = `bus_addr[29:27]` is low and all others are high.
- R2: When `bus_valid` is low, all chip selects and all byte enables are high and `align_err` is low.
- R3: `ext_addr` always equals `bus_addr[26:0]`.
- R4: After reset, region 0 reads width code 01 (16-bit), regions 1 to 7 read width code 00 (8-bit), and every SDRAM flag reads 0.
- R5: A configuration write of width code 00, 01 or 10 to a region from 1 to 7 takes effect from the next clock. Width code 11 is ignored and the previous width is kept.
- R6: A request to set region 0 to width code 00 is ignored, so region 0 keeps its previous width.
- R7: The SDRAM flag can be set only for regions 6 and 7. For regions 0 to 5 it always reads 0.
- R8: In a 32-bit region, a byte write enables lane `addr[1:0]`. A halfword write enables lanes {addr[1],0} and {addr[1],1}. A word write enables all four lanes.
- R9: In a 16-bit region, a byte write enables lane `addr[0]`. A halfword or word write enables lanes 0 and 1.
- R10: In an 8-bit region, every write enables lane 0 only.
- R11: A halfword with `addr[0]`=1, a word with `addr[1:0]`≠0, or size code 11 raises `align_err`. In that case no chip select and no byte enable is asserted.
- R12: A read asserts the chip select but leaves all byte enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region whose configuration is written |
| cfg_width | input | 2 | Requested width code |
| cfg_sdram | input | 1 | Requested SDRAM flag |
| bus_valid | input | 1 | Access enable |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 30 | Internal bus address |
| cs_n | output | 8 | Active-low chip selects, one per region |
| ext_addr | output | 27 | Address inside the region |
| be_n | output | 4 | Active-low byte-lane write enables |
| align_err | output | 1 | Misaligned or reserved-size access |
| sel_width | output | 2 | Width code of the addressed region |
| sel_sdram | output | 1 | SDRAM flag of the addressed region |

## Verification
The assertions check, on every cycle:
- that no more than one chip select is low;
- that an idle or misaligned access drives no select and no lane;
- that a read never drives a lane;
- that region 0 never holds the 8-bit code and keeps its width across a rejected request;
- that the lower six regions never show the SDRAM flag.

Only the bench's scenarios can show that the correct region and the correct lanes are chosen for each size, offset and width. The same holds for the reset values and for whether legal configuration writes land and illegal ones are dropped.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        W8   = 2'b00,
        W16  = 2'b01,
        W32  = 2'b10,
        WRSV = 2'b11
    } width_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSV  = 2'b11
    } size_e;

endpackage

// File: rtl/mbd_cfg_regs.sv
module mbd_cfg_regs
    import mbd_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int SDRAM_FIRST = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [$clog2(NREG)-1:0] cfg_idx,
    input  logic [1:0]              cfg_width,
    input  logic                    cfg_sdram,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [1:0]              rd_width,
    output logic                    rd_sdram
);
    localparam int IDX_W = $clog2(NREG);

    logic [NREG-1:0][1:0] width_q;
    logic [NREG-1:0]      sdram_q;
    width_e               req_w;

    assign req_w = width_e'(cfg_width);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                width_q[r] <= (r == 0) ? W16 : W8;
                sdram_q[r] <= 1'b0;
            end
        end else if (cfg_we) begin
            for (int r = 0; r < NREG; r++) begin
                if (cfg_idx == IDX_W'(r)) begin
                    if (req_w != WRSV && !(r == 0 && req_w == W8))
                        width_q[r] <= cfg_width;
                    if (r >= SDRAM_FIRST)
                        sdram_q[r] <= cfg_sdram;
                end
            end
        end
    end

    assign rd_width = width_q[rd_idx];
    assign rd_sdram = sdram_q[rd_idx];

    AST_R0_NEVER_8: assert property (@(posedge clk) disable iff (!rst_n)
        width_q[0] != W8); // R6
    AST_R0_8_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == '0 && cfg_width == W8) |=> $stable(width_q[0])); // R6
    AST_RSV_WIDTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_width == WRSV) |=> $stable(width_q)); // R5
    AST_LOW_NO_SDRAM: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_q[SDRAM_FIRST-1:0] == '0); // R7

endmodule

// File: rtl/mbd_lane_gen.sv
module mbd_lane_gen
    import mbd_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]       width,
    input  logic [1:0]       size,
    input  logic [1:0]       lo_addr,
    output logic [LANES-1:0] lanes,
    output logic             misalign
);
    width_e w;
    size_e  s;

    assign w = width_e'(width);
    assign s = size_e'(size);

    always_comb begin
        unique case (s)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = lo_addr[0];
            SZ_WORD: misalign = (lo_addr != 2'b00);
            default: misalign = 1'b1;
        endcase
    end

    always_comb begin
        lanes = '0;
        unique case (w)
            W32: begin
                unique case (s)
                    SZ_BYTE: lanes = LANES'(1) << lo_addr;
                    SZ_HALF: lanes = lo_addr[1] ? LANES'(4'b1100) : LANES'(4'b0011);
                    default: lanes = '1;
                endcase
            end
            W16: begin
                if (s == SZ_BYTE)
                    lanes = lo_addr[0] ? LANES'(4'b0010) : LANES'(4'b0001);
                else
                    lanes = LANES'(4'b0011);
            end
            default: lanes = LANES'(1);
        endcase
    end

endmodule

// File: rtl/mbd_region_decode.sv
module mbd_region_decode
    import mbd_pkg::*;
#(
    parameter int ADDR_W      = 30,
    parameter int NREG        = 8,
    parameter int SDRAM_FIRST = 6,
    parameter int LANES       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [$clog2(NREG)-1:0] cfg_idx,
    input  logic [1:0]              cfg_width,
    input  logic                    cfg_sdram,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [1:0]              bus_size,
    input  logic [ADDR_W-1:0]       bus_addr,
    output logic [NREG-1:0]         cs_n,
    output logic [ADDR_W-$clog2(NREG)-1:0] ext_addr,
    output logic [LANES-1:0]        be_n,
    output logic                    align_err,
    output logic [1:0]              sel_width,
    output logic                    sel_sdram
);
    localparam int REG_W  = $clog2(NREG);
    localparam int OFFS_W = ADDR_W - REG_W;

    logic [REG_W-1:0] region;
    logic [LANES-1:0] lanes;
    logic             misalign;
    logic             go;

    assign region   = bus_addr[ADDR_W-1:OFFS_W];
    assign ext_addr = bus_addr[OFFS_W-1:0];

    mbd_cfg_regs #(.NREG(NREG), .SDRAM_FIRST(SDRAM_FIRST)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_width(cfg_width),
        .cfg_sdram(cfg_sdram),
        .rd_idx   (region),
        .rd_width (sel_width),
        .rd_sdram (sel_sdram)
    );

    mbd_lane_gen #(.LANES(LANES)) i_lanes (
        .width   (sel_width),
        .size    (bus_size),
        .lo_addr (bus_addr[1:0]),
        .lanes   (lanes),
        .misalign(misalign)
    );

    assign go        = bus_valid && !misalign;
    assign align_err = bus_valid && misalign;

    always_comb begin
        cs_n = '1;
        if (go)
            cs_n[region] = 1'b0;
    end

    assign be_n = (go && bus_write) ? ~lanes : '1;

    AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (cs_n == '1 && be_n == '1 && !align_err)); // R2
    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (cs_n == '1 && be_n == '1)); // R11
    AST_READ_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> be_n == '1); // R12

endmodule

// File: tb/test_mbd_region_decode.sv
module test_mbd_region_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [1:0]  cfg_width = '0;
    logic        cfg_sdram = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [29:0] bus_addr = '0;
    logic [7:0]  cs_n;
    logic [26:0] ext_addr;
    logic [3:0]  be_n;
    logic        align_err;
    logic [1:0]  sel_width;
    logic        sel_sdram;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbd_region_decode i_mbd_region_decode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_width(cfg_width), .cfg_sdram(cfg_sdram), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .cs_n(cs_n), .ext_addr(ext_addr), .be_n(be_n), .align_err(align_err),
        .sel_width(sel_width), .sel_sdram(sel_sdram)
    );

    // {valid, write, size, addr, exp cs_n, exp be_n, exp err}
    localparam int NV = 16;
    localparam logic [46:0] VEC [NV] = '{
        {1'b1,1'b1,2'd0,30'h08000001,8'hFD,4'b1101,1'b0}, // R1 R8 byte lane1
        {1'b1,1'b1,2'd1,30'h08000002,8'hFD,4'b0011,1'b0}, // R8 half upper
        {1'b1,1'b1,2'd2,30'h08000000,8'hFD,4'b0000,1'b0}, // R8 word
        {1'b1,1'b1,2'd0,30'h08000002,8'hFD,4'b1011,1'b0}, // R8 byte lane2
        {1'b1,1'b1,2'd2,30'h08000002,8'hFF,4'b1111,1'b1}, // R11 word misaligned
        {1'b1,1'b1,2'd1,30'h10000001,8'hFF,4'b1111,1'b1}, // R11 half misaligned
        {1'b1,1'b1,2'd0,30'h10000001,8'hFB,4'b1101,1'b0}, // R9 byte lane1
        {1'b1,1'b1,2'd1,30'h10000002,8'hFB,4'b1100,1'b0}, // R9 half
        {1'b1,1'b1,2'd0,30'h18000003,8'hF7,4'b1110,1'b0}, // R10 lane0 only
        {1'b1,1'b0,2'd2,30'h38000004,8'h7F,4'b1111,1'b0}, // R12 read region7
        {1'b1,1'b1,2'd2,30'h00000000,8'hFE,4'b1100,1'b0}, // R9 word on region0
        {1'b1,1'b0,2'd0,30'h20000000,8'hEF,4'b1111,1'b0}, // R1 region4
        {1'b1,1'b0,2'd0,30'h28000001,8'hDF,4'b1111,1'b0}, // R1 region5
        {1'b1,1'b0,2'd1,30'h30000002,8'hBF,4'b1111,1'b0}, // R1 region6
        {1'b1,1'b1,2'd2,30'h08000000,8'hFF,4'b1111,1'b0}, // R2 idle (valid=0 below)
        {1'b1,1'b1,2'd3,30'h08000000,8'hFF,4'b1111,1'b1}  // R11 reserved size
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [1:0] w, input logic sd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_width = w; cfg_sdram = sd;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [29:0] a);
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = a;
        #1;
    endtask

    initial begin
        #20000;
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        for (int r = 0; r < 8; r++) begin
            look(30'(r) << 27);
            chk($sformatf("R4 width region %0d", r), 32'(sel_width), (r == 0) ? 32'd1 : 32'd0);
            chk($sformatf("R4 sdram region %0d", r), 32'(sel_sdram), 32'd0);
        end
        chk("R2 idle cs after reset", 32'(cs_n), 32'hFF);

        // R6 region0 8-bit request dropped
        cfg_write(3'd0, 2'b00, 1'b0);
        look(30'h00000000);
        chk("R6 region0 kept 16-bit", 32'(sel_width), 32'd1);
        cfg_write(3'd0, 2'b10, 1'b0);
        look(30'h00000000);
        chk("R5 region0 set 32-bit", 32'(sel_width), 32'd2);
        cfg_write(3'd0, 2'b00, 1'b0);
        look(30'h00000000);
        chk("R6 region0 kept 32-bit", 32'(sel_width), 32'd2);
        cfg_write(3'd0, 2'b01, 1'b0);

        // R5 legal and reserved width writes
        cfg_write(3'd1, 2'b10, 1'b0);
        cfg_write(3'd2, 2'b01, 1'b0);
        cfg_write(3'd1, 2'b11, 1'b0);
        look(30'h08000000);
        chk("R5 region1 32-bit, reserved dropped", 32'(sel_width), 32'd2);
        look(30'h10000000);
        chk("R5 region2 16-bit", 32'(sel_width), 32'd1);

        // R7 sdram flag
        cfg_write(3'd3, 2'b00, 1'b1);
        cfg_write(3'd6, 2'b10, 1'b1);
        look(30'h18000000);
        chk("R7 region3 flag stays 0", 32'(sel_sdram), 32'd0);
        look(30'h30000000);
        chk("R7 region6 flag set", 32'(sel_sdram), 32'd1);
        chk("R5 region6 32-bit", 32'(sel_width), 32'd2);
        cfg_write(3'd6, 2'b00, 1'b0);

        // table walk (region1 32, region2 16, region0 16, others 8)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_valid = (i == 14) ? 1'b0 : VEC[i][46];
            bus_write = VEC[i][45];
            bus_size  = VEC[i][44:43];
            bus_addr  = VEC[i][42:13];
            #1;
            chk($sformatf("R1 cs_n vec %0d", i), 32'(cs_n), 32'(VEC[i][12:5]));
            chk($sformatf("R8 be_n vec %0d", i), 32'(be_n), 32'(VEC[i][4:1]));
            chk($sformatf("R11 err vec %0d", i), 32'(align_err), 32'(VEC[i][0]));
            chk($sformatf("R3 ext_addr vec %0d", i), 32'(ext_addr), 32'(VEC[i][39:13]));
        end
        @(negedge clk);
        bus_valid = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule